// File: doc/BRIEF.md
# Reconfigurable-Associativity Level-One Data Cache

This block is an 8 KB level-one data cache made of four equal storage banks of 2 KB each, 64 lines of eight 32-bit words per bank. A two-bit mode input selects the arrangement. The same four banks can act as four ways, as two ways of twice the depth, or as one direct-mapped array of four times the depth. The total size stays 8 KB, because the low tag bits steer each access to a subset of the banks. A separate four-bit mask switches individual banks off, which shrinks the usable capacity.

The processor side takes one word request at a time: a byte address, a write flag and write data, held until the cache raises `reqReady`. Reads that hit complete in the cycle they are presented. A read miss fetches the whole 32-byte line from memory as an eight-beat burst, stores it in the chosen bank and then returns the requested word. Every write goes through to memory. A write that hits also updates the cached word, and a write that misses allocates nothing. Any change of mode or bank mask, and reset, start a sweep over the 64 line slots that clears every valid bit. Requests wait until the sweep ends.

Top module: `cfgcache_top`

## Requirements
- R1: Address fields: bits 4..2 select the word in a line, bits 10..5 select one of 64 line slots in a bank, and the stored tag is always bits 31..11 in every mode. A read returns the 32-bit word at its word-aligned address.
- R2: `cfgMode` 2'b00 is four-way: every enabled bank is a candidate. 2'b01 is two-way: address bit 11 = 0 selects banks 0 and 1, and = 1 selects banks 2 and 3. 2'b10 and 2'b11 are direct-mapped: address bits 12..11 name the single candidate bank. A bank is a candidate only if its `bankOn` bit is also 1.
- R3: A read hits when a candidate bank holds a valid line with a matching tag at the addressed slot. `reqReady` is then high in the same cycle, `rspRdata` carries the word, and no memory request is made. At most one bank hits.
- R4: A read miss raises `memRdReq` with the line-aligned address and accepts eight `memRdValid` beats, word 0 first and then ascending. `reqReady` rises in the cycle after the last beat, with the requested word.
- R5: On a refill, the victim is chosen by a round-robin pointer kept per line slot. Starting at the pointer, the first candidate bank in the order 0,1,2,3 (wrapping) is taken, and the pointer then moves to the bank after the victim. All pointers are 0 after reset.
- R6: Every write raises `memWrReq` once with the request's address and data, and completes with `reqReady` in the cycle `memWrAck` is high. A write that hits also replaces the cached word. Read and write requests to memory are never raised together.
- R7: A write miss does not fill a line, so a following read of that address misses and refills.
- R8: A bank whose `bankOn` bit is 0 never hits and is never filled. With no candidate bank, a read still fetches the line and returns the word without storing it.
- R9: After reset, and after any change of `cfgMode` or `bankOn` seen while idle, all lines are invalidated over 64 cycles. During this sweep `reqReady`, `memRdReq` and `memWrReq` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | Associativity: 00 four-way, 01 two-way, 1x direct-mapped |
| bankOn | input | 4 | Per-bank enable mask |
| reqValid | input | 1 | Processor request present, held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the word |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Request completes at this clock edge |
| rspRdata | output | 32 | Read data, valid with reqReady on reads |
| memRdReq | output | 1 | Line refill request, held through the burst |
| memRdAddr | output | 32 | Line-aligned refill address |
| memRdValid | input | 1 | A refill beat is present |
| memRdData | input | 32 | Refill beat data |
| memWrReq | output | 1 | Write-through request |
| memWrAddr | output | 32 | Write-through address |
| memWrData | output | 32 | Write-through data |
| memWrAck | input | 1 | Memory accepts the write |

## Verification
The hardest state to reach from the ports is a refill whose victim comes from the round-robin pointer rather than from an empty slot. That only happens once every candidate bank at one line slot holds a different tag. The stimulus table therefore sends five tags to the same slot in four-way mode. It then predicts from R5 which earlier tag was evicted, and probes it by counting refill bursts. The mode and mask are then changed between runs of requests, so each change forces a sweep. Conflicts that exist in one arrangement but not in another (the same slot in direct-mapped versus two-way, or a single enabled bank) show up as refill counts.

// File: rtl/cfgcache_pkg.sv
package cfgcache_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int DATA_W    = 32;

  typedef enum logic [2:0] {
    ST_FLUSH,
    ST_IDLE,
    ST_FILL,
    ST_RESP,
    ST_WRITE
  } cacheState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearSet;     // invalidate all banks at clearIdx
    logic fillWrite;    // store refill beat into victim
    logic fillLast;     // last beat: write tag/valid, advance pointer
    logic captureWord;  // keep beat if it is the requested word
    logic wrHitUpdate;  // write hit: replace cached word
  } ctrlStrobe_t;

endpackage

// File: rtl/cfgcache_waydec.sv
module cfgcache_waydec
  import cfgcache_pkg::*;
(
  input  logic [1:0]           modeQ,
  input  logic [NUM_BANKS-1:0] bankOnQ,
  input  logic [BANK_W-1:0]    selBits,
  output logic [NUM_BANKS-1:0] enVec
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic inGroup;
    always_comb begin
      unique casez (modeQ)
        2'b00:   inGroup = 1'b1;
        2'b01:   inGroup = (BANK_W'(b) >> 1) == BANK_W'(selBits[0]);
        default: inGroup = BANK_W'(b) == selBits;
      endcase
    end
    assign enVec[b] = inGroup & bankOnQ[b];
  end

endmodule

// File: rtl/cfgcache_dp.sv
module cfgcache_dp
  import cfgcache_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WORDS = 8,
  parameter int TAG_W = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobe_t              strobe,
  input  logic [$clog2(SETS)-1:0]  idxIn,
  input  logic [$clog2(WORDS)-1:0] wordIn,
  input  logic [TAG_W-1:0]         tagIn,
  input  logic [DATA_W-1:0]        wdataIn,
  input  logic [NUM_BANKS-1:0]     enVec,
  input  logic [$clog2(WORDS)-1:0] beatIdx,
  input  logic [$clog2(SETS)-1:0]  clearIdx,
  input  logic [DATA_W-1:0]        fillData,
  output logic                     hit,
  output logic [DATA_W-1:0]        hitData,
  output logic [DATA_W-1:0]        fillWord
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WRD_W = $clog2(WORDS);
  localparam int LOC_W = IDX_W + WRD_W;

  logic [TAG_W-1:0]  tagMem   [NUM_BANKS][SETS];
  logic              validMem [NUM_BANKS][SETS];
  logic [DATA_W-1:0] dataMem  [NUM_BANKS][SETS*WORDS];
  logic [BANK_W-1:0] rrPtr    [SETS];

  logic [NUM_BANKS-1:0] hitVec;
  logic [BANK_W-1:0]    hitBank;
  logic [BANK_W-1:0]    victim;
  logic                 victimOk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign hitVec[b] = enVec[b] && validMem[b][idxIn] && (tagMem[b][idxIn] == tagIn);
  end

  always_comb begin
    hitBank = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hitVec[b]) hitBank = BANK_W'(b);
  end

  assign hit     = |hitVec;
  assign hitData = dataMem[hitBank][{idxIn, wordIn}];

  // round robin from the slot's pointer, first enabled bank wins
  always_comb begin
    victim   = '0;
    victimOk = 1'b0;
    for (int k = NUM_BANKS - 1; k >= 0; k--) begin
      logic [BANK_W-1:0] cand;
      cand = rrPtr[idxIn] + BANK_W'(k);
      if (enVec[cand]) begin
        victim   = cand;
        victimOk = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int s = 0; s < SETS; s++) validMem[b][s] <= 1'b0;
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else begin
      if (strobe.clearSet)
        for (int b = 0; b < NUM_BANKS; b++) validMem[b][clearIdx] <= 1'b0;
      if (strobe.fillLast && victimOk) begin
        validMem[victim][idxIn] <= 1'b1;
        rrPtr[idxIn]            <= victim + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillLast && victimOk) tagMem[victim][idxIn] <= tagIn;
    if (strobe.fillWrite && victimOk)
      dataMem[victim][LOC_W'({idxIn, beatIdx})] <= fillData;
    else if (strobe.wrHitUpdate)
      dataMem[hitBank][LOC_W'({idxIn, wordIn})] <= wdataIn;
    if (strobe.captureWord && beatIdx == wordIn) fillWord <= fillData;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec)); // R3
  AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fillWrite |-> !hit); // R4

endmodule

// File: rtl/cfgcache_ctrl.sv
module cfgcache_ctrl
  import cfgcache_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfgMode,
  input  logic [NUM_BANKS-1:0]     bankOn,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     hit,
  input  logic                     memRdValid,
  input  logic                     memWrAck,
  output ctrlStrobe_t              strobe,
  output logic [$clog2(WORDS)-1:0] beatIdx,
  output logic [$clog2(SETS)-1:0]  clearIdx,
  output logic [1:0]               modeQ,
  output logic [NUM_BANKS-1:0]     bankOnQ,
  output logic                     reqReady,
  output logic                     memRdReq,
  output logic                     memWrReq,
  output logic                     respFromFill
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WRD_W = $clog2(WORDS);

  cacheState_t state, nextState;
  logic [IDX_W-1:0] flushCnt;
  logic [WRD_W-1:0] beatCnt;
  logic cfgMatch;

  assign cfgMatch = (cfgMode == modeQ) && (bankOn == bankOnQ);

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    unique case (state)
      ST_FLUSH: begin
        strobe.clearSet = 1'b1;
        if (flushCnt == IDX_W'(SETS - 1)) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (!cfgMatch) nextState = ST_FLUSH;
        else if (reqValid && reqWrite) begin
          strobe.wrHitUpdate = hit;
          nextState          = ST_WRITE;
        end else if (reqValid && hit) reqReady = 1'b1;
        else if (reqValid) nextState = ST_FILL;
      end
      ST_FILL: begin
        strobe.fillWrite   = memRdValid;
        strobe.captureWord = memRdValid;
        if (memRdValid && beatCnt == WRD_W'(WORDS - 1)) begin
          strobe.fillLast = 1'b1;
          nextState       = ST_RESP;
        end
      end
      ST_RESP: begin
        reqReady  = 1'b1;
        nextState = ST_IDLE;
      end
      ST_WRITE: begin
        reqReady = memWrAck;
        if (memWrAck) nextState = ST_IDLE;
      end
      default: nextState = ST_FLUSH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FLUSH;
      flushCnt <= '0;
      beatCnt  <= '0;
      modeQ    <= '0;
      bankOnQ  <= '0;
    end else begin
      state <= nextState;
      if (state == ST_FLUSH) begin
        modeQ    <= cfgMode;
        bankOnQ  <= bankOn;
        flushCnt <= flushCnt + 1'b1;
      end else flushCnt <= '0;
      if (state == ST_FILL && memRdValid) beatCnt <= beatCnt + 1'b1;
      else if (state != ST_FILL) beatCnt <= '0;
    end
  end

  assign beatIdx      = beatCnt;
  assign clearIdx     = flushCnt;
  assign memRdReq     = (state == ST_FILL);
  assign memWrReq     = (state == ST_WRITE);
  assign respFromFill = (state == ST_RESP);

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FLUSH |-> !reqReady && !memRdReq && !memWrReq); // R9
  AST_CFG_TRIGGERS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !cfgMatch) |=> state == ST_FLUSH); // R9
  AST_RESP_AFTER_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RESP |-> $past(memRdValid) && $past(state) == ST_FILL); // R4
  AST_WRITE_NO_ALLOCATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cfgMatch && reqValid && reqWrite) |=> state == ST_WRITE); // R7
  AST_NO_RD_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRdReq && memWrReq)); // R6

endmodule

// File: rtl/cfgcache_top.sv
module cfgcache_top
  import cfgcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int WORDS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfgMode,
  input  logic [NUM_BANKS-1:0] bankOn,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqReady,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 memRdReq,
  output logic [ADDR_W-1:0]    memRdAddr,
  input  logic                 memRdValid,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 memWrReq,
  output logic [ADDR_W-1:0]    memWrAddr,
  output logic [DATA_W-1:0]    memWrData,
  input  logic                 memWrAck
);

  localparam int WRD_W = $clog2(WORDS);
  localparam int OFF_W = WRD_W + 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  ctrlStrobe_t          strobe;
  logic [WRD_W-1:0]     beatIdx;
  logic [IDX_W-1:0]     clearIdx;
  logic [1:0]           modeQ;
  logic [NUM_BANKS-1:0] bankOnQ;
  logic [NUM_BANKS-1:0] enVec;
  logic                 hit;
  logic                 respFromFill;
  logic [DATA_W-1:0]    hitData;
  logic [DATA_W-1:0]    fillWord;

  cfgcache_waydec u_dec (
    .modeQ   (modeQ),
    .bankOnQ (bankOnQ),
    .selBits (reqAddr[OFF_W+IDX_W +: BANK_W]),
    .enVec   (enVec)
  );

  cfgcache_ctrl #(.SETS(SETS), .WORDS(WORDS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgMode      (cfgMode),
    .bankOn       (bankOn),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .hit          (hit),
    .memRdValid   (memRdValid),
    .memWrAck     (memWrAck),
    .strobe       (strobe),
    .beatIdx      (beatIdx),
    .clearIdx     (clearIdx),
    .modeQ        (modeQ),
    .bankOnQ      (bankOnQ),
    .reqReady     (reqReady),
    .memRdReq     (memRdReq),
    .memWrReq     (memWrReq),
    .respFromFill (respFromFill)
  );

  cfgcache_dp #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .idxIn    (reqAddr[OFF_W +: IDX_W]),
    .wordIn   (reqAddr[2 +: WRD_W]),
    .tagIn    (reqAddr[ADDR_W-1 -: TAG_W]),
    .wdataIn  (reqWdata),
    .enVec    (enVec),
    .beatIdx  (beatIdx),
    .clearIdx (clearIdx),
    .fillData (memRdData),
    .hit      (hit),
    .hitData  (hitData),
    .fillWord (fillWord)
  );

  assign rspRdata  = respFromFill ? fillWord : hitData;
  assign memRdAddr = {reqAddr[ADDR_W-1:OFF_W], OFF_W'(0)};
  assign memWrAddr = reqAddr;
  assign memWrData = reqWdata;

  AST_DIRECT_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    modeQ[1] |-> $onehot0(enVec)); // R2
  AST_OFF_BANK_NOT_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (enVec & ~bankOnQ) == '0); // R8

endmodule

// File: tb/cfgcache_top_tb_top.sv
module cfgcache_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfgMode;
  logic [3:0]  bankOn;
  logic        reqValid, reqWrite;
  logic [31:0] reqAddr, reqWdata;
  logic        reqReady;
  logic [31:0] rspRdata;
  logic        memRdReq, memRdValid, memWrReq, memWrAck;
  logic [31:0] memRdAddr, memRdData, memWrAddr, memWrData;

  always #10 clk = ~clk;

  cfgcache_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfgMode(cfgMode), .bankOn(bankOn),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspRdata(rspRdata),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrAck(memWrAck)
  );

  int nChecks = 0, nFail = 0;
  int fillCnt = 0, wrCnt = 0, beat = 0;
  logic [31:0] memImg [logic [31:0]];

  function automatic logic [31:0] memRead(logic [31:0] a);
    return memImg.exists(a) ? memImg[a] : (a ^ 32'h5A5A_0000);
  endfunction

  // memory model, driven at the falling edge
  always @(negedge clk) begin
    if (memRdReq) begin
      if (beat == 0) fillCnt++;
      memRdValid = 1'b1;
      memRdData  = memRead(memRdAddr + 32'(beat * 4));
      beat++;
    end else begin
      memRdValid = 1'b0;
      beat = 0;
    end
    if (memWrReq) begin
      memImg[memWrAddr] = memWrData;
      wrCnt++;
      memWrAck = 1'b1;
    end else memWrAck = 1'b0;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc);
    cyc = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    #1;
    while (!reqReady && cyc < 2000) begin
      @(negedge clk); #1; cyc++;
    end
    if (!reqReady) begin
      nChecks++; nFail++;
      $display("FAIL request timeout addr %h: actual no ready expected ready", a);
    end
    rd = rspRdata;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  // read with expected refill count and data (data from the memory image)
  task automatic rdExp(string req, logic [31:0] a, int expFill);
    logic [31:0] rd; int cyc; int f0;
    f0 = fillCnt;
    doReq(1'b0, a, 32'h0, rd, cyc);
    chk(req, 32'(fillCnt - f0), 32'(expFill));
    chk(req, rd, memRead(a));
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic [3:0]  expFill;
    logic [3:0]  expWr;
  } vec_t;

  // four-way, all banks on, slot 3 unless noted
  localparam vec_t VECS [16] = '{
    '{1'b0, 32'h0000_0064, 32'h0, 32'h5A5A_0064, 4'd1, 4'd0},  // R4 first fill -> bank0
    '{1'b0, 32'h0000_007C, 32'h0, 32'h5A5A_007C, 4'd0, 4'd0},  // R3 R1 word 7 hit
    '{1'b0, 32'h0000_0864, 32'h0, 32'h5A5A_0864, 4'd1, 4'd0},  // R5 -> bank1
    '{1'b0, 32'h0000_1064, 32'h0, 32'h5A5A_1064, 4'd1, 4'd0},  // R5 -> bank2
    '{1'b0, 32'h0000_1864, 32'h0, 32'h5A5A_1864, 4'd1, 4'd0},  // R5 -> bank3
    '{1'b0, 32'h0000_0064, 32'h0, 32'h5A5A_0064, 4'd0, 4'd0},  // R3 all four resident
    '{1'b0, 32'h0000_2064, 32'h0, 32'h5A5A_2064, 4'd1, 4'd0},  // R5 evicts bank0
    '{1'b0, 32'h0000_0864, 32'h0, 32'h5A5A_0864, 4'd0, 4'd0},  // R5 bank1 kept
    '{1'b0, 32'h0000_0064, 32'h0, 32'h5A5A_0064, 4'd1, 4'd0},  // R5 refill, evicts bank1
    '{1'b0, 32'h0000_0864, 32'h0, 32'h5A5A_0864, 4'd1, 4'd0},  // R5 refill, evicts bank2
    '{1'b1, 32'h0000_1868, 32'hDEAD_BEEF, 32'h0, 4'd0, 4'd1},  // R6 write hit
    '{1'b0, 32'h0000_1868, 32'h0, 32'hDEAD_BEEF, 4'd0, 4'd0},  // R6 cached word updated
    '{1'b1, 32'h0000_4000, 32'h1234_5678, 32'h0, 4'd0, 4'd1},  // R7 write miss
    '{1'b0, 32'h0000_4000, 32'h0, 32'h1234_5678, 4'd1, 4'd0},  // R7 no allocate, R6 memory got it
    '{1'b0, 32'h0000_4000, 32'h0, 32'h1234_5678, 4'd0, 4'd0},  // R3 now resident
    '{1'b0, 32'h0000_1064, 32'h0, 32'h5A5A_1064, 4'd1, 4'd0}   // R5 bank2 was evicted
  };

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    logic [31:0] rd; int cyc; int f0, w0;
    rst_n = 1'b0; cfgMode = 2'b00; bankOn = 4'hF;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    memRdValid = 1'b0; memRdData = '0; memWrAck = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset quiet", {29'b0, reqReady, memRdReq, memWrReq}, 32'h0);
    rst_n = 1'b1;

    // R9 sweep after reset holds the first read; R1 slot 62 word 1
    f0 = fillCnt;
    doReq(1'b0, 32'h0000_07C4, 32'h0, rd, cyc);
    chk("R9 sweep delays first request", 32'(cyc >= 72), 32'h1);
    chk("R1 slot 62 read data", rd, 32'h5A5A_07C4);
    chk("R4 one refill", 32'(fillCnt - f0), 32'd1);

    foreach (VECS[i]) begin
      f0 = fillCnt; w0 = wrCnt;
      doReq(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, cyc);
      nChecks++;
      if (32'(fillCnt - f0) !== 32'(VECS[i].expFill) || 32'(wrCnt - w0) !== 32'(VECS[i].expWr) ||
          (!VECS[i].wr && rd !== VECS[i].expData)) begin
        nFail++;
        $display("FAIL R3-R7 vector %0d: actual data %h fills %0d writes %0d expected data %h fills %0d writes %0d",
                 i, rd, fillCnt - f0, wrCnt - w0, VECS[i].expData, VECS[i].expFill, VECS[i].expWr);
      end
    end

    // R2 direct-mapped; the change also flushes (R9)
    @(negedge clk); cfgMode = 2'b10;
    rdExp("R9 flushed after mode change", 32'h0000_0064, 1);
    rdExp("R2 direct other bank", 32'h0000_0864, 1);
    rdExp("R2 direct separate banks keep line", 32'h0000_0064, 0);
    rdExp("R2 direct same bank", 32'h0000_2064, 1);
    rdExp("R2 direct conflict evicted", 32'h0000_0064, 1);
    rdExp("R6 write-through reached memory", 32'h0000_1868, 1);

    // R2 two-way: 0x64 and 0x1064 share pair 0/1, 0x864 uses pair 2/3
    @(negedge clk); cfgMode = 2'b01;
    rdExp("R2 two-way fill a", 32'h0000_0064, 1);
    rdExp("R2 two-way fill b", 32'h0000_1064, 1);
    rdExp("R2 two-way fill other pair", 32'h0000_0864, 1);
    rdExp("R2 two-way a resident", 32'h0000_0064, 0);
    rdExp("R2 two-way b resident", 32'h0000_1064, 0);
    rdExp("R2 two-way other pair resident", 32'h0000_0864, 0);

    // R8 a single enabled bank holds one line per slot
    @(negedge clk); cfgMode = 2'b00; bankOn = 4'b0001;
    rdExp("R8 single bank fill", 32'h0000_0064, 1);
    rdExp("R8 single bank replace", 32'h0000_0864, 1);
    rdExp("R8 disabled banks not filled", 32'h0000_0064, 1);

    // R8 no bank enabled: every read refills, nothing stored
    @(negedge clk); bankOn = 4'b0000;
    rdExp("R8 no bank bypass", 32'h0000_0064, 1);
    rdExp("R8 no bank never hits", 32'h0000_0064, 1);

    summary();
  end

endmodule